// File: doc/BRIEF.md
# SPI Serial NVRAM Target Model

This block acts as the target side of a mode-0 SPI link and answers like a small serial non-volatile memory, so that a host-side SPI controller and its driver sequences can be exercised against a realistic partner. The SPI pins are sampled with the system clock. After chip select falls, the block decodes the first byte as an opcode and then serves status polls, identification, streaming reads from a small internal byte array, and page writes into that array.

The block tracks a write-enable latch and a busy flag. A page write is taken only while the latch is set. When chip select rises after such a write, the busy flag stays high for a programmable number of clocks. While busy is set, only status polling gets an answer. A deep power-down state silences the block until the wake opcode arrives. Of the 24-bit address, only the low bits that index the array are kept.

The system clock must run at least eight times faster than SCK, and each SCK phase must last at least four clocks.

Top module: `nvram_spi_target`

## Requirements
- R1: After reset the status byte reads 0x00, the block is not in power-down, and while chip select is high both `spi_miso` and `spi_miso_oe` are 0.
- R2: Opcode 0x05 returns the status byte on every following byte of the frame: bit 1 is the write-enable latch, bit 0 is busy, and bits 7..2 are 0.
- R3: Opcode 0x9F returns three bytes, manufacturer (`ID_MFR`), type (`ID_TYPE`) and the size code `MEM_AW` (capacity 2^code bytes), followed by 0x00 for any further bytes.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R5: Opcode 0x03 is followed by a 24-bit address, most significant byte first. Address bits at and above `MEM_AW` are ignored. Data then streams out from the array with the address incrementing after each byte until chip select rises.
- R6: Opcode 0x0A with the latch set takes a 24-bit address and then data bytes that are stored at incrementing offsets. An offset that passes the end of the 256-byte page wraps to the start of the same page.
- R7: Opcode 0x0A with the latch clear stores nothing and does not set busy.
- R8: When chip select rises after an accepted page write whose address is complete, busy is set for `BUSY_CYCLES` clocks. When busy ends, busy and the latch both clear.
- R9: While busy is set, only opcode 0x05 is answered. Every other opcode, and every byte after it, is dropped, and MISO returns 0x00.
- R10: Opcode 0xB9 enters deep power-down. There every opcode except 0xAB is ignored and `spi_miso_oe` stays 0. Opcode 0xAB leaves power-down.
- R11: The block samples MOSI on the rising SCK edge, sends MSB first, updates MISO after the falling SCK edge, and drives `spi_miso_oe` high while it is selected and not in power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 when not enabled |
| spi_miso_oe | output | 1 | High when the block drives MISO |

## Verification
The hardest state to reach from the pins is the busy window. It exists only between the rise of chip select after an accepted page write and the end of the programming delay, and inside that window every opcode except the status poll must vanish without a trace. The bench first sets the latch, then writes a page that crosses the page boundary. Inside a delay that it sets long enough, it sends a status poll, a full read frame and a latch-clear frame, and checks that the status still shows both the latch and busy. After the delay it checks that both bits have cleared and that the wrapped data sits at the start of the page.

// File: rtl/nvram_pkg.sv
// Package: opcode values and command-state encoding shared by the
// NVRAM target model. Opcode values are fixed by the link protocol.
package nvram_pkg;

    localparam logic [7:0] OP_STATUS    = 8'h05;
    localparam logic [7:0] OP_IDENT     = 8'h9F;
    localparam logic [7:0] OP_READ      = 8'h03;
    localparam logic [7:0] OP_LATCH_SET = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_PROGRAM   = 8'h0A;
    localparam logic [7:0] OP_SLEEP     = 8'hB9;
    localparam logic [7:0] OP_WAKE      = 8'hAB;

    localparam int PAGE_AW = 8;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_RD,
        ST_WR,
        ST_STAT,
        ST_ID,
        ST_DROP
    } cmd_state_t;

endpackage

// File: rtl/nvram_spi_shifter.sv
// Module: nvram_spi_shifter
// Samples the SPI pins with the system clock, finds SCK and CS edges,
// assembles received bytes (mode 0, MSB first) and shifts reply bytes out.
// Assumes: each SCK phase lasts at least four clk cycles, and SCK idles low.
module nvram_spi_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    input  logic [7:0] tx_byte_i,
    output logic [7:0] rx_byte_o,
    output logic       rx_valid_o,
    output logic       tx_load_o,
    output logic       frame_end_o,
    output logic       selected_o,
    output logic       miso_o
);

    logic       sck_s, sck_d, cs_n_s, cs_n_d, mosi_s;
    logic       sck_rise, sck_fall;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;

    // Capture the asynchronous pins and keep one delayed copy for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s  <= 1'b0;
            sck_d  <= 1'b0;
            cs_n_s <= 1'b1;
            cs_n_d <= 1'b1;
            mosi_s <= 1'b0;
        end else begin
            sck_s  <= sck_i;
            sck_d  <= sck_s;
            cs_n_s <= cs_n_i;
            cs_n_d <= cs_n_s;
            mosi_s <= mosi_i;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;

    // Receive path: shift MOSI on rising SCK and flag each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= 3'd0;
            rx_sh      <= 7'd0;
            rx_byte_o  <= 8'd0;
            rx_valid_o <= 1'b0;
        end else if (cs_n_s) begin
            bit_cnt    <= 3'd0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (sck_rise) begin
                rx_sh   <= {rx_sh[5:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_byte_o  <= {rx_sh, mosi_s};
                    rx_valid_o <= 1'b1;
                end
            end
        end
    end

    // Transmit path: load a new reply byte on the falling edge at a byte boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            tx_sh     <= 8'd0;
            tx_load_o <= 1'b0;
        end else begin
            tx_load_o <= 1'b0;
            if (sck_fall) begin
                if (bit_cnt == 3'd0) begin
                    tx_sh     <= tx_byte_i;
                    tx_load_o <= 1'b1;
                end else begin
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    assign frame_end_o = cs_n_s & ~cs_n_d;
    assign selected_o  = ~cs_n_s;
    assign miso_o      = tx_sh[7];

    // A byte is complete only in the cycle right after a rising SCK edge.
    assert_byte_on_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(sck_rise));

    // Raising chip select always restarts the bit count.
    assert_cs_restarts_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (bit_cnt == 3'd0));

endmodule

// File: rtl/nvram_status.sv
// Module: nvram_status
// Holds the write-enable latch, the busy flag with its programming-delay
// counter, and the deep power-down flag.
// Assumes: the command decoder gates its requests; BUSY_CYCLES >= 1.
module nvram_status #(
    parameter int BUSY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_wel_i,
    input  logic clr_wel_i,
    input  logic start_busy_i,
    input  logic enter_pd_i,
    input  logic exit_pd_i,
    output logic wel_o,
    output logic busy_o,
    output logic pd_o
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Programming delay: load on start and count down. At the end, drop busy and the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            busy_o <= 1'b0;
            wel_o  <= 1'b0;
        end else if (start_busy_i) begin
            cnt    <= CNT_W'(BUSY_CYCLES);
            busy_o <= 1'b1;
        end else if (busy_o) begin
            if (cnt == CNT_W'(1)) begin
                cnt    <= '0;
                busy_o <= 1'b0;
                wel_o  <= 1'b0;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end else if (set_wel_i) begin
            wel_o <= 1'b1;
        end else if (clr_wel_i) begin
            wel_o <= 1'b0;
        end
    end

    // Deep power-down flag follows the sleep and wake requests.
    always_ff @(posedge clk) begin
        if (!rst_n)          pd_o <= 1'b0;
        else if (enter_pd_i) pd_o <= 1'b1;
        else if (exit_pd_i)  pd_o <= 1'b0;
    end

    // Power-down is never entered while busy is set.
    assert_pd_excludes_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pd_o |-> !busy_o);

    // The latch is clear whenever busy has just ended.
    assert_latch_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !wel_o);

endmodule

// File: rtl/nvram_store.sv
// Module: nvram_store
// Byte array with a combinational read port and a synchronous write port
// that share one address. The contents are not reset.
module nvram_store #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (we_i) mem[addr_i] <= wdata_i;
    end

    assign rdata_o = mem[addr_i];

endmodule

// File: rtl/nvram_spi_target.sv
// Module: nvram_spi_target (top)
// Serial NVRAM target model: decodes the opcode, gates it on power-down and
// busy, collects the address and routes data between SPI and the array.
// Assumes: 9 <= MEM_AW <= 24; clk runs at least 8x faster than SCK.
module nvram_spi_target #(
    parameter int         MEM_AW      = 10,
    parameter int         BUSY_CYCLES = 1000,
    parameter logic [7:0] ID_MFR      = 8'hC2,
    parameter logic [7:0] ID_TYPE     = 8'h22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    import nvram_pkg::*;

    localparam logic [7:0] ID_SIZE = 8'(MEM_AW);

    logic [7:0]        rx_byte, tx_byte, mem_rdata;
    logic              rx_valid, tx_load, frame_end, selected, miso_raw;
    logic              wel, busy, pd;
    logic              set_wel, clr_wel, start_busy, enter_pd, exit_pd;
    logic              op_seen, mem_we;
    cmd_state_t        state;
    logic [1:0]        addr_cnt, id_idx;
    logic              is_write, wr_armed;
    logic [MEM_AW-1:0] addr_q;

    nvram_spi_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_i       (spi_sck),
        .cs_n_i      (spi_cs_n),
        .mosi_i      (spi_mosi),
        .tx_byte_i   (tx_byte),
        .rx_byte_o   (rx_byte),
        .rx_valid_o  (rx_valid),
        .tx_load_o   (tx_load),
        .frame_end_o (frame_end),
        .selected_o  (selected),
        .miso_o      (miso_raw)
    );

    nvram_status #(.BUSY_CYCLES(BUSY_CYCLES)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_wel_i    (set_wel),
        .clr_wel_i    (clr_wel),
        .start_busy_i (start_busy),
        .enter_pd_i   (enter_pd),
        .exit_pd_i    (exit_pd),
        .wel_o        (wel),
        .busy_o       (busy),
        .pd_o         (pd)
    );

    nvram_store #(.AW(MEM_AW)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .addr_i  (addr_q),
        .wdata_i (rx_byte),
        .rdata_o (mem_rdata)
    );

    // Requests to the status block, gated by power-down and busy.
    always_comb begin
        op_seen    = rx_valid && (state == ST_OPC);
        set_wel    = op_seen && !pd && !busy && (rx_byte == OP_LATCH_SET);
        clr_wel    = op_seen && !pd && !busy && (rx_byte == OP_LATCH_CLR);
        enter_pd   = op_seen && !pd && !busy && (rx_byte == OP_SLEEP);
        exit_pd    = op_seen &&  pd && (rx_byte == OP_WAKE);
        start_busy = frame_end && wr_armed;
        mem_we     = rx_valid && (state == ST_WR);
    end

    // Command sequencer: opcode decode, address collection and data stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_OPC;
            addr_cnt <= 2'd0;
            id_idx   <= 2'd0;
            is_write <= 1'b0;
            wr_armed <= 1'b0;
            addr_q   <= '0;
        end else if (frame_end) begin
            state    <= ST_OPC;
            wr_armed <= 1'b0;
        end else if (rx_valid) begin
            case (state)
                ST_OPC: begin
                    addr_cnt <= 2'd0;
                    id_idx   <= 2'd0;
                    if (pd) begin
                        state <= ST_DROP;
                    end else if (busy) begin
                        state <= (rx_byte == OP_STATUS) ? ST_STAT : ST_DROP;
                    end else begin
                        case (rx_byte)
                            OP_STATUS: state <= ST_STAT;
                            OP_IDENT:  state <= ST_ID;
                            OP_READ: begin
                                state    <= ST_ADDR;
                                is_write <= 1'b0;
                            end
                            OP_PROGRAM: begin
                                state    <= wel ? ST_ADDR : ST_DROP;
                                is_write <= 1'b1;
                            end
                            default:   state <= ST_DROP;
                        endcase
                    end
                end
                ST_ADDR: begin
                    addr_q   <= {addr_q[MEM_AW-9:0], rx_byte};
                    addr_cnt <= addr_cnt + 2'd1;
                    if (addr_cnt == 2'd2) begin
                        state    <= is_write ? ST_WR : ST_RD;
                        wr_armed <= is_write;
                    end
                end
                ST_WR: begin
                    addr_q[PAGE_AW-1:0] <= addr_q[PAGE_AW-1:0] + 8'd1;
                end
                default: ;
            endcase
        end else if (tx_load) begin
            if (state == ST_RD) addr_q <= addr_q + MEM_AW'(1);
            if (state == ST_ID && id_idx != 2'd3) id_idx <= id_idx + 2'd1;
        end
    end

    // Reply byte offered to the shifter for the next byte slot.
    always_comb begin
        case (state)
            ST_STAT: tx_byte = {6'd0, wel, busy};
            ST_RD:   tx_byte = mem_rdata;
            ST_ID: begin
                case (id_idx)
                    2'd0:    tx_byte = ID_MFR;
                    2'd1:    tx_byte = ID_TYPE;
                    2'd2:    tx_byte = ID_SIZE;
                    default: tx_byte = 8'd0;
                endcase
            end
            default: tx_byte = 8'd0;
        endcase
    end

    assign spi_miso_oe = selected & ~pd;
    assign spi_miso    = miso_raw & spi_miso_oe;

    // A byte is stored only while the latch is set.
    assert_write_needs_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

    // No byte is stored while a programming delay runs.
    assert_no_write_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !busy);

    // A programming delay starts only for a write taken under the latch.
    assert_busy_start_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_busy |-> wel);

endmodule

// File: tb/nvram_spi_target_tb_top.sv
module nvram_spi_target_tb_top;

    localparam int HALF  = 6;
    localparam int BUSY  = 2000;
    localparam int NVEC  = 6;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] exp;
        logic       chk;
        logic [3:0] req;
    } vec_t;

    // Two-byte frames: opcode, then one byte whose reply is optionally checked.
    localparam vec_t VECS [NVEC] = '{
        '{8'h05, 8'h00, 1'b1, 4'd1},   // R1 reset status
        '{8'h06, 8'h00, 1'b0, 4'd4},   // R4 set latch
        '{8'h05, 8'h02, 1'b1, 4'd4},   // R4 latch visible
        '{8'h04, 8'h00, 1'b0, 4'd4},   // R4 clear latch
        '{8'h05, 8'h00, 1'b1, 4'd4},   // R4 latch gone
        '{8'h9F, 8'hC2, 1'b1, 4'd3}    // R3 first ID byte
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] txq [8];
    logic [7:0] rxq [8];
    logic       oe_mid;

    always #2 clk = ~clk;

    nvram_spi_target #(.MEM_AW(10), .BUSY_CYCLES(BUSY)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck     (spi_sck),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic run_frame(input int n);
        logic [7:0] r;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            spi_byte(txq[i], r);
            rxq[i] = r;
            if (i == 0) oe_mid = spi_miso_oe;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic set_frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                             input logic [7:0] b3, input logic [7:0] b4, input logic [7:0] b5);
        txq[0] = b0; txq[1] = b1; txq[2] = b2; txq[3] = b3; txq[4] = b4; txq[5] = b5;
        txq[6] = 8'hFF; txq[7] = 8'hFF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: idle outputs after reset
        check("R1 miso_oe idle", {7'd0, spi_miso_oe}, 8'h00);
        check("R1 miso idle", {7'd0, spi_miso}, 8'h00);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            set_frame(VECS[v].op, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
            run_frame(2);
            if (VECS[v].chk) begin
                checks++;
                if (rxq[1] !== VECS[v].exp) begin
                    fails++;
                    $display("FAIL R%0d table entry %0d actual %02h expected %02h",
                             VECS[v].req, v, rxq[1], VECS[v].exp);
                end
            end
        end

        // R3: full identification sequence and trailing zero
        set_frame(8'h9F, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(5);
        check("R3 id mfr", rxq[1], 8'hC2);
        check("R3 id type", rxq[2], 8'h22);
        check("R3 id size", rxq[3], 8'h0A);
        check("R3 id tail", rxq[4], 8'h00);
        check("R11 oe while selected", {7'd0, oe_mid}, 8'h01);

        // R2: status repeats on every byte
        set_frame(8'h06, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(1);
        set_frame(8'h05, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(3);
        check("R2 status byte1", rxq[1], 8'h02);
        check("R2 status byte2", rxq[2], 8'h02);

        // R6: page write at 0x1FE crossing the page end
        set_frame(8'h0A, 8'h00, 8'h01, 8'hFE, 8'h11, 8'h22);
        txq[6] = 8'h33; txq[7] = 8'h44;
        run_frame(8);

        // R8/R9: inside the programming delay
        set_frame(8'h05, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(2);
        check("R8 busy and latch set", rxq[1], 8'h03);
        set_frame(8'h03, 8'h00, 8'h01, 8'h00, 8'hFF, 8'hFF);
        run_frame(5);
        check("R9 read dropped while busy", rxq[4], 8'h00);
        set_frame(8'h04, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(1);
        set_frame(8'h05, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(2);
        check("R9 latch-clear dropped while busy", rxq[1], 8'h03);

        repeat (BUSY + 100) @(negedge clk);
        set_frame(8'h05, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(2);
        check("R8 busy and latch cleared", rxq[1], 8'h00);

        // R7: write with latch clear is ignored
        set_frame(8'h0A, 8'h00, 8'h01, 8'h00, 8'h99, 8'h99);
        run_frame(6);
        set_frame(8'h05, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(2);
        check("R7 no busy after refused write", rxq[1], 8'h00);

        // R5: read with upper address bits set
        set_frame(8'h03, 8'hFF, 8'h01, 8'hFE, 8'hFF, 8'hFF);
        run_frame(6);
        check("R5 read 0x1FE", rxq[4], 8'h11);
        check("R5 read auto-increment", rxq[5], 8'h22);

        // R6 wrap data, and R7 data untouched
        set_frame(8'h03, 8'h00, 8'h01, 8'h00, 8'hFF, 8'hFF);
        run_frame(6);
        check("R6 wrapped byte at page start", rxq[4], 8'h33);
        check("R7 byte not overwritten", rxq[4], 8'h33);
        check("R6 wrapped second byte", rxq[5], 8'h44);

        // R10: deep power-down
        set_frame(8'hB9, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(1);
        set_frame(8'h05, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(2);
        check("R10 oe low in power-down", {7'd0, oe_mid}, 8'h00);
        check("R10 status silent", rxq[1], 8'h00);
        set_frame(8'h06, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(1);
        set_frame(8'hAB, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(1);
        set_frame(8'h05, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(2);
        check("R10 latch-set ignored in power-down", rxq[1], 8'h00);
        check("R10 oe back after wake", {7'd0, oe_mid}, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule